// File: doc/BRIEF.md
# Multi-Channel Edge-Aligned PWM Timer

This block is a 16-bit up-counter that drives four single-edge PWM outputs. A period register sets where the counter wraps back to zero, so one cycle lasts period+1 enabled clocks. Each channel compares the shared count against its own match value. A 2-bit mode then turns that comparison into a normal waveform, an inverted waveform, or a fixed low or high level.

Software uses a small synchronous port. It writes the period, the four match values and one packed mode word, and reads them back through the same address. Period and match writes go into shadow copies. Those copies are moved into the working registers only when the counter wraps, so a cycle that is already running is never cut short. Mode changes take effect on the next clock. The enable input pauses counting without losing the count.

Top module: `mcpwm_top`

## Requirements
- R1: While `en` is high the counter rises by one per clock. In the clock where it equals the active period value it returns to zero, so every cycle spans period+1 enabled clocks.
- R2: While `en` is low the counter holds its value, and any channel whose mode does not change keeps its output level.
- R3: Mode code 2'b00 gives a low output while the count is below the channel's active match value and a high output from that value up to the wrap. A match of 0 therefore gives a constant high, and a match above the period gives a constant low.
- R4: Mode code 2'b01 gives the opposite level to R3: high while the count is below the match value and low from the match value on.
- R5: Mode code 2'b10 holds the output low and mode code 2'b11 holds it high, whatever the count.
- R6: Each output is registered. The level that belongs to count value k appears one clock after the counter holds k.
- R7: A write to the period register (address 0) or to a match register (addresses 1 to 4, for channels 0 to 3) changes only a shadow copy, which reads back at once. The working value that the counter or comparator uses is loaded only at the wrap to zero.
- R8: The mode word sits at address 5. Channel 0 uses bits [1:0], channel 1 bits [3:2], channel 2 bits [7:6] and channel 3 bits [9:8]. Bits [5:4] and [15:10] are reserved: they read as 0 and ignore writes, so a write of 16'hFFFF reads back as 16'h03CF.
- R9: Addresses 6 and 7 are unmapped. They read as 0, and writes to them change no register.
- R10: After reset the counter is 0, every output is 0, and every register reads 0. All modes are therefore 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; counter holds while low |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
Six configurations are each run over two full cycles and compared sample by sample against a model built from the requirements. They include all four modes in one cycle with equal match values, so only polarity and forcing can tell the channels apart. They also cover match values of 0, of the period and above the period, a period of 0 (a one-clock cycle), and mixed modes on a long cycle. These runs separate a comparator that uses `>` from one that uses `>=`, and a wrap one count early from one one count late. An output that is off by one clock shows up as a phase shift. A directed test stops the counter in mid-cycle and rewrites a match value. That separates a shadowed update from an immediate one, and confirms the hold and the immediate effect of a forced mode. Further checks cover reserved-bit masking, unmapped addresses and the reset state.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

    // Per-channel output behaviour, 2-bit code stored in the mode word
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_INVERT   = 2'b01,
        MODE_FORCE_LO = 2'b10,
        MODE_FORCE_HI = 2'b11
    } pwm_mode_e;

    // Register address plan
    localparam int ADDR_PERIOD = 0;
    localparam int ADDR_MATCH0 = 1;

    // Slot left unused in the packed mode word
    localparam int RSV_SLOT = 2;

    // Write request bundle seen by the register bank
    typedef struct packed {
        logic        valid;
        logic [7:0]  addr;
    } wr_sel_t;

    function automatic int mode_addr(int nch);
        return ADDR_MATCH0 + nch;
    endfunction

    function automatic int addr_width(int nch);
        return $clog2(nch + 2);
    endfunction

    // Bit slot (two bits each) holding a channel's mode code
    function automatic int slot_of(int ch);
        return (ch >= RSV_SLOT) ? ch + 1 : ch;
    endfunction

    // Output level for a mode, given whether the count has reached the match
    function automatic logic mode_level(pwm_mode_e m, logic reached);
        logic lvl;
        case (m)
            MODE_NORMAL:   lvl = reached;
            MODE_INVERT:   lvl = !reached;
            MODE_FORCE_LO: lvl = 1'b0;
            default:       lvl = 1'b1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/mcpwm_counter.sv
module mcpwm_counter
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_act,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic at_end;

    assign at_end = (cnt == period_act);
    assign wrap   = en && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            if (at_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Counting steps by one below the period (R1)
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        (en && cnt != period_act) |=> (cnt == $past(cnt) + 1'b1));

    // Reaching the period returns the count to zero (R1)
    assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == period_act) |=> (cnt == '0));

    // Disabled counter holds (R2)
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == $past(cnt)));

    // Reset clears the count (R10)
    assert_cnt_reset_R10: assert property (@(posedge clk)
        rst |=> (cnt == '0));

endmodule

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
    import mcpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [CNT_W-1:0]             wdata,
    input  logic                         wrap,
    output logic [CNT_W-1:0]             rdata,
    output logic [CNT_W-1:0]             period_act,
    output logic [NUM_CH-1:0][CNT_W-1:0] match_act,
    output logic [NUM_CH-1:0][1:0]       mode_q
);

    localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(ADDR_PERIOD);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(mode_addr(NUM_CH));

    function automatic logic [CNT_W-1:0] build_mask();
        logic [CNT_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            m[2*slot_of(ch) +: 2] = 2'b11;
        end
        return m;
    endfunction

    localparam logic [CNT_W-1:0] MODE_MASK = build_mask();

    logic [CNT_W-1:0]             period_sh;
    logic [NUM_CH-1:0][CNT_W-1:0] match_sh;
    logic [CNT_W-1:0]             mode_word;
    wr_sel_t                      wsel;

    assign wsel.valid = wr_en;
    assign wsel.addr  = 8'(addr);

    // Period: shadow written by the port, working copy loaded at wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            period_sh  <= '0;
            period_act <= '0;
        end else begin
            if (wsel.valid && wsel.addr == 8'(A_PERIOD)) begin
                period_sh <= wdata;
            end
            if (wrap) begin
                period_act <= period_sh;
            end
        end
    end

    // Per-channel match shadows and modes
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(ADDR_MATCH0 + g);
        localparam int                SLOT    = slot_of(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                match_sh[g]  <= '0;
                match_act[g] <= '0;
                mode_q[g]    <= MODE_NORMAL;
            end else begin
                if (wsel.valid && wsel.addr == 8'(A_MATCH)) begin
                    match_sh[g] <= wdata;
                end
                if (wsel.valid && wsel.addr == 8'(A_MODE)) begin
                    mode_q[g] <= wdata[2*SLOT +: 2];
                end
                if (wrap) begin
                    match_act[g] <= match_sh[g];
                end
            end
        end

        // Working match only moves at a wrap (R7)
        assert_match_shadow_R7: assert property (@(posedge clk) disable iff (rst)
            !wrap |=> (match_act[g] == $past(match_act[g])));

        // Mode fields come out of reset as 00 (R10)
        assert_mode_reset_R10: assert property (@(posedge clk)
            rst |=> (mode_q[g] == MODE_NORMAL));
    end

    // Packed mode word for readback; reserved slots stay zero
    always_comb begin
        mode_word = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            mode_word[2*slot_of(ch) +: 2] = mode_q[ch];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_PERIOD) begin
            rdata = period_sh;
        end else if (addr == A_MODE) begin
            rdata = mode_word;
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr == ADDR_W'(ADDR_MATCH0 + ch)) begin
                rdata = match_sh[ch];
            end
        end
    end

    // Working period only moves at a wrap (R7)
    assert_period_shadow_R7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> (period_act == $past(period_act)));

    // Reserved mode bits never read back as one (R8)
    assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (addr == A_MODE) |-> ((rdata & ~MODE_MASK) == '0));

    // Addresses past the mode word read zero (R9)
    assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
        (addr > A_MODE) |-> (rdata == '0));

endmodule

// File: rtl/mcpwm_chan.sv
module mcpwm_chan
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] match_act,
    input  logic [1:0]       mode,
    output logic             out_q
);

    pwm_mode_e m;
    logic      reached;
    logic      lvl;

    assign m       = pwm_mode_e'(mode);
    assign reached = (cnt >= match_act);
    assign lvl     = mode_level(m, reached);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else begin
            out_q <= lvl;
        end
    end

    // Forced low ignores the count (R5)
    assert_force_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> !out_q);

    // Forced high ignores the count (R5)
    assert_force_hi_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> out_q);

    // Output is low after reset (R10)
    assert_out_reset_R10: assert property (@(posedge clk)
        rst |=> !out_q);

endmodule

// File: rtl/mcpwm_top.sv
module mcpwm_top
    import mcpwm_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int NUM_CH = 4,
    localparam int ADDR_W = addr_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [CNT_W-1:0]             cnt;
    logic                         wrap;
    logic [CNT_W-1:0]             period_act;
    logic [NUM_CH-1:0][CNT_W-1:0] match_act;
    logic [NUM_CH-1:0][1:0]       mode_q;

    initial begin
        assert (2 * (NUM_CH + 1) <= CNT_W)
            else $error("mode word does not fit the data width");
    end

    mcpwm_regs #(
        .CNT_W  (CNT_W),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .wrap       (wrap),
        .rdata      (rdata),
        .period_act (period_act),
        .match_act  (match_act),
        .mode_q     (mode_q)
    );

    mcpwm_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .period_act (period_act),
        .cnt        (cnt),
        .wrap       (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        mcpwm_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .cnt       (cnt),
            .match_act (match_act[g]),
            .mode      (mode_q[g]),
            .out_q     (pwm_out[g])
        );
    end

endmodule

// File: tb/mcpwm_top_tb.sv
`timescale 1ns/1ps
module mcpwm_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  pwm_out;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mcpwm_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    typedef struct packed {
        logic [15:0]      per;
        logic [3:0][15:0] m;      // {ch3, ch2, ch1, ch0}
        logic [15:0]      modes;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd7,  {16'd3,  16'd3,  16'd3,  16'd3}, 16'h0384},
        '{16'd9,  {16'd12, 16'd10, 16'd0,  16'd0}, 16'h0000},
        '{16'd9,  {16'd4,  16'd10, 16'd9,  16'd0}, 16'h0145},
        '{16'd0,  {16'd1,  16'd0,  16'd1,  16'd0}, 16'h0140},
        '{16'd15, {16'd2,  16'd8,  16'd15, 16'd1}, 16'h0301},
        '{16'd4,  {16'd2,  16'd2,  16'd2,  16'd2}, 16'h004B}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en = 1'b0;
        wr_en = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1;
        addr = a;
        wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [15:0] exp);
        addr = a;
        #1;
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    // Mode field position per R8: ch0 [1:0], ch1 [3:2], ch2 [7:6], ch3 [9:8]
    function automatic logic [1:0] mode_of(logic [15:0] w, int ch);
        int slot;
        slot = (ch < 2) ? ch : ch + 1;
        return w[2*slot +: 2];
    endfunction

    // Expected level from R3, R4, R5
    function automatic logic model(logic [1:0] md, int k, int mt);
        case (md)
            2'b00:   return (k >= mt);
            2'b01:   return (k < mt);
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string mode_tag(logic [1:0] md);
        case (md)
            2'b00:   return "R3";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // ---- Reset state: R10 ----
        do_reset();
        chk("R10 outputs after reset", 32'(pwm_out), 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd_chk($sformatf("R10 reg %0d after reset", a), 3'(a), 16'h0);
        end

        // ---- Unmapped addresses: R9 ----
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'hA5A5);
        for (int a = 0; a < 8; a++) begin
            rd_chk($sformatf("R9 reg %0d after unmapped writes", a), 3'(a), 16'h0);
        end

        // ---- Reserved mode bits: R8 ----
        wr(3'd5, 16'hFFFF);
        rd_chk("R8 mode word all ones", 3'd5, 16'h03CF);
        wr(3'd5, 16'hFC30);
        rd_chk("R8 reserved-only write", 3'd5, 16'h0000);

        // ---- Vector table: R1, R3, R4, R5, R6 ----
        foreach (VECS[v]) begin
            do_reset();
            wr(3'd0, VECS[v].per);
            for (int c = 0; c < 4; c++) wr(3'(1 + c), VECS[v].m[c]);
            wr(3'd5, VECS[v].modes);
            rd_chk($sformatf("R7 period readback vec%0d", v), 3'd0, VECS[v].per);
            en = 1'b1;
            tick();  // first wrap loads working copies
            // After each further edge the output shows count k (R1 wrap, R6 latency)
            for (int j = 0; j < 2 * (int'(VECS[v].per) + 1); j++) begin
                tick();
                for (int c = 0; c < 4; c++) begin
                    logic [1:0] md;
                    int k;
                    md = mode_of(VECS[v].modes, c);
                    k  = j % (int'(VECS[v].per) + 1);
                    chk($sformatf("R1 R6 %s vec%0d ch%0d k=%0d", mode_tag(md), v, c, k),
                        32'(pwm_out[c]), 32'(model(md, k, int'(VECS[v].m[c]))));
                end
            end
            en = 1'b0;
        end

        // ---- Shadow, hold and immediate mode: R7, R2, R5 ----
        do_reset();
        wr(3'd0, 16'd9);
        for (int c = 0; c < 4; c++) wr(3'(1 + c), 16'd5);
        en = 1'b1;
        tick();          // wrap, working copies loaded
        tick();          // count 0 -> 1
        tick();          // count 1 -> 2
        en = 1'b0;
        tick();          // holds at 2, output reflects 2
        wr(3'd1, 16'd1); // ch0 shadow match = 1 mid-cycle
        rd_chk("R7 match shadow readback", 3'd1, 16'd1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk($sformatf("R7 R2 ch0 held low while paused i=%0d", i),
                32'(pwm_out[0]), 32'h0);
        end
        wr(3'd5, 16'h000C);  // ch1 forced high (bits [3:2] = 11)
        tick();
        chk("R5 forced high applies while paused", 32'(pwm_out[1]), 32'h1);
        chk("R2 ch2 keeps level while paused", 32'(pwm_out[2]), 32'h0);
        en = 1'b1;
        tick();          // output reflects 2
        tick();          // output reflects 3, old match still 5
        chk("R7 old match kept until wrap", 32'(pwm_out[0]), 32'h0);
        for (int i = 0; i < 7; i++) tick();  // through count 9 and wrap
        chk("R7 new match at count 0", 32'(pwm_out[0]), 32'h0);
        tick();
        chk("R7 new match at count 1", 32'(pwm_out[0]), 32'h1);
        chk("R3 unchanged channel low at count 1", 32'(pwm_out[3]), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule